// File: doc/BRIEF.md
# Bit-addressable bidirectional GPIO port

This block is a parallel port of up to 16 pins behind a small register interface. Each pin has a direction bit, an open-drain select bit and an output latch bit. An input latch copies the pad levels once per state-time tick, whatever direction each pin has. A read of the data register returns, pin by pin, either the sampled level (input pins) or the output latch (output pins). The same per-pin choice supplies the base value for single-bit set and clear commands. Those commands are carried out as a read-modify-write, and the whole modified word goes back into the output latch.

Software writes a full word with `wr_en` and `reg_addr`, and changes a single data bit with `bit_set` or `bit_clr` together with `bit_sel`. The interface has no handshake and no back-pressure. Every command is taken in the cycle it is presented, and the read data is combinational. With the parameter `HAS_DIR` set to 0, the block builds an input-only variant that has no direction storage, and its pads are never driven.

Top module: `bitio_port`

## Requirements
- R1: A pin whose direction bit is 1 is an output. In push-pull mode its `pad_oe` bit is 1. A pin whose direction bit is 0 has `pad_oe` 0 (high impedance).
- R2: The input latch loads `pad_in` on the TICK_DIV-th rising edge after reset is released and on every TICK_DIV-th edge after that. It holds its value at all other edges. Loading takes place for output pins as well.
- R3: A data write to an input pin changes only the output latch and leaves the pad undriven. When the pin is later made an output, the stored value appears on `pad_out`.
- R4: `reg_addr` selects what `rd_data` shows: 0 = data, 1 = direction, 2 = open-drain select, 3 = reads zero and ignores writes. For each data bit, an output pin shows its output latch and an input pin shows its input latch.
- R5: `bit_set` or `bit_clr` alone (not both together) forms a base word. The base takes the output latch for output pins and the input latch for input pins. Bit `bit_sel` of the base is forced to 1 (set) or 0 (clear), and the whole result is stored in the output latch. Asserting both commands together changes nothing.
- R6: When a pin's open-drain bit is 1, `pad_oe` = direction AND NOT latch, and `pad_out` is 0 for that pin. When the open-drain bit is 0, `pad_out` equals the latch bit.
- R7: When a set/clear and a data write fall in the same cycle, the set/clear is applied first and the full-word write then replaces it. A direction write in the same cycle as a set/clear takes effect, and the set/clear uses the direction from before that write.
- R8: After reset, the direction, open-drain, output latch and input latch are all 0, so every pin is a high-impedance input.
- R9: With `HAS_DIR`=0, `pad_oe` is always 0, the direction register reads 0, and writes to it are ignored. Data reads and the set/clear base both come from the input latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 open-drain |
| wr_data | input | WIDTH | Write word |
| bit_sel | input | $clog2(WIDTH) | Pin index for set/clear |
| bit_set | input | 1 | Single-bit set command |
| bit_clr | input | 1 | Single-bit clear command |
| rd_data | output | WIDTH | Combinational read of the selected register |
| pad_in | input | WIDTH | Pad levels |
| pad_out | output | WIDTH | Pad drive values |
| pad_oe | output | WIDTH | Pad driver enables |

## Verification
A set/clear command and a full-word register write can arrive in the same cycle. The bench forces this with directed cases: a data write paired with a set of a different bit, and a direction write paired with a set whose base depends on the old direction. It also lets the two collide freely in a long random run. Each outcome is compared with a bench reference model that first applies the set/clear and then the word write. The final latch content is read back through the data register after all pins have been made outputs.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_OD   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pio_tick_gen.sv
module pio_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R2: ticks never come back to back when the divider exceeds one
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pio_in_sampler.sv
module pio_in_sampler #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] in_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else if (tick) in_q <= pad_in;
  end

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(in_q));
  a_r2_capture_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (in_q == $past(pad_in)));
endmodule

// File: rtl/pio_ctrl_regs.sv
module pio_ctrl_regs
  import pio_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit HAS_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         reg_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] od_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) od_q <= '0;
    else if (wr_en && reg_addr == REG_OD) od_q <= wr_data;
  end

  generate
    if (HAS_DIR) begin : g_dir
      always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else if (wr_en && reg_addr == REG_DIR) dir_q <= wr_data;
      end
      a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == REG_DIR) |=> (dir_q == $past(wr_data)));
    end else begin : g_no_dir
      assign dir_q = '0;
    end
  endgenerate

  a_r6_od_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == REG_OD) |=> (od_q == $past(wr_data)));
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch
  import pio_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         reg_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDXW-1:0]  bit_sel,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] in_q,
  output logic [WIDTH-1:0] out_q
);
  localparam logic [IDXW:0] WLIM = (IDXW+1)'(WIDTH);

  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] nxt;
  logic             rmw_go;
  logic             word_wr;

  assign word_wr = wr_en && (reg_addr == REG_DATA);
  assign rmw_go  = (bit_set ^ bit_clr) && ({1'b0, bit_sel} < WLIM);

  always_comb begin
    base = (dir_q & out_q) | (~dir_q & in_q);
    nxt  = out_q;
    if (rmw_go) begin
      nxt          = base;
      nxt[bit_sel] = bit_set;
    end
    if (word_wr) nxt = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else out_q <= nxt;
  end

  // R7: the full-word write overrides a same-cycle set/clear
  a_r7_word_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> (out_q == $past(wr_data)));
  a_r5_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && !bit_clr && !word_wr && ({1'b0, bit_sel} < WLIM)) |=> out_q[$past(bit_sel)]);
  a_r5_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clr && !bit_set && !word_wr && ({1'b0, bit_sel} < WLIM)) |=> !out_q[$past(bit_sel)]);
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_wr && !(bit_set ^ bit_clr)) |=> $stable(out_q));
endmodule

// File: rtl/bitio_port.sv
module bitio_port
  import pio_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int TICK_DIV = 4,
  parameter bit HAS_DIR  = 1'b1,
  parameter int IDXW     = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDXW-1:0]  bit_sel,
  input  logic             bit_set,
  input  logic             bit_clr,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  reg_sel_e         sel;
  logic             tick;
  logic [WIDTH-1:0] in_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] od_q;
  logic [WIDTH-1:0] out_q;

  assign sel = reg_sel_e'(reg_addr);

  pio_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  pio_in_sampler #(.WIDTH(WIDTH)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pad_in(pad_in), .in_q(in_q));

  pio_ctrl_regs #(.WIDTH(WIDTH), .HAS_DIR(HAS_DIR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(sel),
    .wr_data(wr_data), .dir_q(dir_q), .od_q(od_q));

  pio_out_latch #(.WIDTH(WIDTH), .IDXW(IDXW)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(sel),
    .wr_data(wr_data), .bit_sel(bit_sel), .bit_set(bit_set),
    .bit_clr(bit_clr), .dir_q(dir_q), .in_q(in_q), .out_q(out_q));

  always_comb begin
    unique case (sel)
      REG_DATA: rd_data = (dir_q & out_q) | (~dir_q & in_q);
      REG_DIR:  rd_data = dir_q;
      REG_OD:   rd_data = od_q;
      default:  rd_data = '0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_pad
      assign pad_oe[gi]  = dir_q[gi] & ~(od_q[gi] & out_q[gi]);
      assign pad_out[gi] = out_q[gi] & ~od_q[gi];
    end
    if (!HAS_DIR) begin : g_ro_chk
      a_r9_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == '0);
    end
  endgenerate

  a_r1_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);
  a_r6_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & od_q & out_q) == '0);
  a_r6_od_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);
endmodule

// File: tb/bitio_port_tb_top.sv
module bitio_port_tb_top;
  localparam int W        = 16;
  localparam int IW       = 4;
  localparam int DIV      = 4;
  localparam int CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [W-1:0]  wr_data = '0;
  logic [IW-1:0] bit_sel = '0;
  logic          bit_set = 1'b0;
  logic          bit_clr = 1'b0;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  rd_data, pad_out, pad_oe;
  logic [W-1:0]  ro_rd, ro_out, ro_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  bitio_port #(.WIDTH(W), .TICK_DIV(DIV), .HAS_DIR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .bit_sel(bit_sel), .bit_set(bit_set), .bit_clr(bit_clr),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  bitio_port #(.WIDTH(W), .TICK_DIV(DIV), .HAS_DIR(1'b0)) dut_ro_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .bit_sel(bit_sel), .bit_set(bit_set), .bit_clr(bit_clr),
    .rd_data(ro_rd), .pad_in(pad_in), .pad_out(ro_out), .pad_oe(ro_oe));

  // reference model state
  logic [W-1:0] m_dir, m_od, m_out, m_in, r_od, r_out;
  int m_cnt;

  function automatic logic [W-1:0] next_out(logic [W-1:0] dir, logic [W-1:0] outl,
      logic [W-1:0] inl, logic we, logic [1:0] a, logic [W-1:0] d,
      logic [IW-1:0] s, logic st, logic cl);
    logic [W-1:0] r;
    r = outl;
    if (st ^ cl) begin
      r = (dir & outl) | (~dir & inl);
      r[s] = st;
    end
    if (we && a == 2'd0) r = d;
    return r;
  endfunction

  function automatic logic [W-1:0] exp_rd(logic [1:0] a, logic [W-1:0] dir,
      logic [W-1:0] od, logic [W-1:0] outl, logic [W-1:0] inl);
    case (a)
      2'd0: return (dir & outl) | (~dir & inl);
      2'd1: return dir;
      2'd2: return od;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir <= '0; m_od <= '0; m_out <= '0; m_in <= '0; m_cnt <= 0;
      r_od <= '0; r_out <= '0;
    end else begin
      m_cnt <= (m_cnt == DIV-1) ? 0 : m_cnt + 1;
      if (m_cnt == DIV-1) m_in <= pad_in;
      m_out <= next_out(m_dir, m_out, m_in, wr_en, reg_addr, wr_data, bit_sel, bit_set, bit_clr);
      r_out <= next_out('0, r_out, m_in, wr_en, reg_addr, wr_data, bit_sel, bit_set, bit_clr);
      if (wr_en && reg_addr == 2'd1) m_dir <= wr_data;
      if (wr_en && reg_addr == 2'd2) begin m_od <= wr_data; r_od <= wr_data; end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, rd_data, exp_rd(reg_addr, m_dir, m_od, m_out, m_in));
    chk("R1 R6 oe", pad_oe, m_dir & ~(m_od & m_out));
    chk("R6 out", pad_out, m_out & ~m_od);
    chk("R9 ro oe", ro_oe, '0);
    chk("R9 ro rd", ro_rd, exp_rd(reg_addr, '0, r_od, r_out, m_in));
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d,
      input logic [IW-1:0] s, input logic st, input logic cl, input logic [W-1:0] pin,
      input string tag);
    wr_en = we; reg_addr = a; wr_data = d; bit_sel = s;
    bit_set = st; bit_clr = cl; pad_in = pin;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input logic [W-1:0] pin, input string tag);
    step(1'b0, 2'd0, '0, '0, 1'b0, 1'b0, pin, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R8: reset state seen at every register address
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a);
      #1;
      chk("R8 rd", rd_data, '0);
    end
    chk("R8 oe", pad_oe, '0);
    rst_n = 1'b1;
    idle(16'h0000, "R8");

    // R2: latch follows the pad only on ticks
    for (int k = 0; k < 6; k++) idle(16'hF0F0, "R2 sample");
    chk("R2 loaded", rd_data, 16'hF0F0);

    // R3: write to input pins stays off the pad
    step(1'b1, 2'd0, 16'h00A5, '0, 1'b0, 1'b0, 16'hF0F0, "R3");
    chk("R3 no drive", pad_oe, 16'h0000);
    chk("R3 input read", rd_data, 16'hF0F0);
    step(1'b1, 2'd1, 16'h00FF, '0, 1'b0, 1'b0, 16'hF0F0, "R3");
    chk("R3 appears", pad_out, 16'h00A5);

    // R5: base mixes latch (outputs) with sampled pins (inputs)
    step(1'b0, 2'd0, '0, 4'd15, 1'b0, 1'b1, 16'hF0F0, "R5");
    step(1'b1, 2'd1, 16'hFFFF, '0, 1'b0, 1'b0, 16'hF0F0, "R5");
    idle(16'hF0F0, "R5");
    chk("R5 rmw base", rd_data, 16'h70A5);

    // R7: collisions
    step(1'b1, 2'd0, 16'h1234, 4'd15, 1'b1, 1'b0, 16'hF0F0, "R7");
    chk("R7 write wins", rd_data, 16'h1234);
    step(1'b1, 2'd1, 16'h0000, 4'd0, 1'b1, 1'b0, 16'hF0F0, "R7");
    idle(16'hF0F0, "R7");
    chk("R7 input view", rd_data, 16'hF0F0);
    step(1'b1, 2'd1, 16'hFFFF, '0, 1'b0, 1'b0, 16'hF0F0, "R7");
    idle(16'hF0F0, "R7");
    chk("R7 old dir base", rd_data, 16'h1235);

    // R6: open drain
    step(1'b1, 2'd2, 16'h000F, '0, 1'b0, 1'b0, 16'hF0F0, "R6");
    chk("R6 oe", pad_oe, 16'hFFFA);
    chk("R6 out", pad_out, 16'h1230);

    // R5: set and clear together do nothing
    step(1'b0, 2'd0, '0, 4'd4, 1'b1, 1'b1, 16'hF0F0, "R5 both");
    chk("R5 both ignored", rd_data, 16'h1235);

    // R4: unused address
    step(1'b1, 2'd3, 16'hFFFF, '0, 1'b0, 1'b0, 16'hF0F0, "R4 addr3");
    chk("R4 addr3 zero", rd_data, 16'h0000);

    // R9: input-only variant ignores direction writes
    step(1'b1, 2'd1, 16'hFFFF, '0, 1'b0, 1'b0, 16'hF0F0, "R9");
    chk("R9 dir reads 0", ro_rd, 16'h0000);

    // random mix with collisions
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r0, r1;
      r0 = $urandom;
      r1 = $urandom;
      step(r0[0] & r0[1], r0[3:2], r1[15:0], r0[7:4], r0[8] & r0[9], r0[10] & r0[11],
           (r0[12] ? r1[31:16] : pad_in), "R4 R5 R7 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule